// File: doc/BRIEF.md
# Paged Program Counter with Return Stack

This block produces the instruction fetch address of a small 8-bit controller core. The address is 11 bits wide and spans 2048 words. Those words fall into four 512-word pages. Once per clock the block takes a decoded control-flow operation from the instruction decoder and computes the next address. The sources for that address are:

- the incrementer;
- the ALU result, for a write to the PC register;
- the instruction's address field;
- two page-select status bits;
- a two-entry return-address stack.

Short jumps, short calls and PC register writes take their upper bits from the page-select bits. Long jumps and long calls take the whole address from the instruction and ignore the paging. Calls push the address after the call. Returns pop the stack.

The low eight address bits are also provided as an output, so the register file can present the PC as a readable register. When a return-with-literal moves its literal into the working register, that move is handled outside this block. Here it behaves exactly like a plain return.

Top module: `pc_seq`

## Requirements
- R1: While `rst_n` is low, `fetch_addr` is 7FFh and the stack is emptied. The stack entries are cleared to 000h.
- R2: `op` = 0 (sequential) loads `fetch_addr + 1`, wrapping from 7FFh to 000h.
- R3: `op` = 1 (skip) loads `fetch_addr + 2`, wrapping modulo 2048.
- R4: `op` = 2 (PC register write) loads `{page_sel[1:0], 1'b0, alu_res[7:0]}`.
- R5: `op` = 3 (short jump) loads `{page_sel[1:0], imm_addr[8:0]}`.
- R6: `op` = 4 (short call) loads `{page_sel[1:0], 1'b0, imm_addr[7:0]}` and pushes `fetch_addr + 1`.
- R7: `op` = 5 (long jump) and `op` = 6 (long call) load `imm_addr[10:0]` with `page_sel` ignored. A long call pushes `fetch_addr + 1`.
- R8: `op` = 7 (return) and `op` = 8 (return with literal) load the top stack entry and pop one level.
- R9: A push onto a full two-entry stack discards the oldest entry.
- R10: A pop from an empty stack returns the last entry that was popped. Before any push, that value is 000h.
- R11: `pc_low` always equals `fetch_addr[7:0]`. Codes 9 to 15 on `op` act as sequential.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op | input | 4 | Control-flow operation code, 0 to 8 |
| imm_addr | input | 11 | Address field of the instruction word |
| alu_res | input | 8 | ALU result for PC register writes |
| page_sel | input | 2 | Page-select status bits |
| fetch_addr | output | 11 | Current program fetch address |
| pc_low | output | 8 | Low byte of the PC, as a readable register |

## Verification
The transfers are exercised with page bits that differ from the upper bits of the address field. This shows whether a given transfer uses paging, bypasses it, or forces bit 8 to zero. Call chains are run three deep and then unwound past empty. The return order separates a correct overwrite of the oldest entry from one that drops the newest, and it shows which value an empty pop repeats. Increments and skips are started at 7FEh and 7FFh to test wrap-around. A reset in the middle of a run, followed by a return, confirms that the stack is cleared.

// File: rtl/pc_pkg.sv
package pc_pkg;
  parameter int PAGE_W = 2;
  parameter int LOW_W  = 8;
  localparam int ADDR_W = PAGE_W + LOW_W + 1;
  localparam logic [ADDR_W-1:0] RESET_ADDR = '1;

  typedef enum logic [3:0] {
    FLOW_SEQ    = 4'd0,
    FLOW_SKIP   = 4'd1,
    FLOW_REGWR  = 4'd2,
    FLOW_SJUMP  = 4'd3,
    FLOW_SCALL  = 4'd4,
    FLOW_LJUMP  = 4'd5,
    FLOW_LCALL  = 4'd6,
    FLOW_RET    = 4'd7,
    FLOW_RETLIT = 4'd8
  } flow_op_e;

  // Advance an address by a small step, wrapping at the top of memory.
  function automatic logic [ADDR_W-1:0] pc_advance(input logic [ADDR_W-1:0] pc,
                                                   input logic [1:0] step);
    return pc + ADDR_W'(step);
  endfunction

  // Join page bits, bit 8 and the low byte into a paged address.
  function automatic logic [ADDR_W-1:0] page_join(input logic [PAGE_W-1:0] page,
                                                  input logic hi,
                                                  input logic [LOW_W-1:0] low);
    return {page, hi, low};
  endfunction
endpackage

// File: rtl/pc_ret_stack.sv
module pc_ret_stack
  import pc_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              pop,
  input  logic [ADDR_W-1:0] push_val,
  output logic [ADDR_W-1:0] top,
  output logic [$clog2(DEPTH+1)-1:0] depth
);
  localparam int CNT_W = $clog2(DEPTH+1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic [ADDR_W-1:0] ent [DEPTH];
  logic [CNT_W-1:0]  cnt;

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_ent
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          ent[g] <= '0;
        end else if (push) begin
          if (g == 0) ent[g] <= push_val;
          else        ent[g] <= ent[(g == 0) ? 0 : g-1];
        end else if (pop && cnt > CNT_W'(1)) begin
          if (g < DEPTH-1) ent[g] <= ent[(g < DEPTH-1) ? g+1 : g];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (push && cnt != FULL) cnt <= cnt + CNT_W'(1);
    else if (pop && cnt != '0)  cnt <= cnt - CNT_W'(1);
  end

  assign top   = ent[0];
  assign depth = cnt;
endmodule

// File: rtl/pc_next.sv
module pc_next
  import pc_pkg::*;
(
  input  logic [3:0]        op,
  input  logic [ADDR_W-1:0] pc,
  input  logic [ADDR_W-1:0] imm,
  input  logic [LOW_W-1:0]  alu,
  input  logic [PAGE_W-1:0] page,
  input  logic [ADDR_W-1:0] stk_top,
  output logic [ADDR_W-1:0] nxt,
  output logic              push,
  output logic              pop,
  output logic [ADDR_W-1:0] ret_addr
);
  flow_op_e kind;
  assign kind     = flow_op_e'(op);
  assign ret_addr = pc_advance(pc, 2'd1);

  always_comb begin
    nxt  = pc_advance(pc, 2'd1);
    push = 1'b0;
    pop  = 1'b0;
    case (kind)
      FLOW_SKIP:   nxt = pc_advance(pc, 2'd2);
      FLOW_REGWR:  nxt = page_join(page, 1'b0, alu);
      FLOW_SJUMP:  nxt = page_join(page, imm[LOW_W], imm[LOW_W-1:0]);
      FLOW_SCALL: begin
        nxt  = page_join(page, 1'b0, imm[LOW_W-1:0]);
        push = 1'b1;
      end
      FLOW_LJUMP:  nxt = imm;
      FLOW_LCALL: begin
        nxt  = imm;
        push = 1'b1;
      end
      FLOW_RET, FLOW_RETLIT: begin
        nxt = stk_top;
        pop = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/pc_seq.sv
module pc_seq
  import pc_pkg::*;
#(
  parameter int STACK_DEPTH = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [3:0]           op,
  input  logic [ADDR_W-1:0]    imm_addr,
  input  logic [LOW_W-1:0]     alu_res,
  input  logic [PAGE_W-1:0]    page_sel,
  output logic [ADDR_W-1:0]    fetch_addr,
  output logic [LOW_W-1:0]     pc_low
);
  localparam int CNT_W = $clog2(STACK_DEPTH+1);

  logic [ADDR_W-1:0] pc_q, pc_d, stk_top, ret_addr;
  logic              push_w, pop_w;
  logic [CNT_W-1:0]  stk_depth;

  pc_next u_next (
    .op(op), .pc(pc_q), .imm(imm_addr), .alu(alu_res), .page(page_sel),
    .stk_top(stk_top), .nxt(pc_d), .push(push_w), .pop(pop_w),
    .ret_addr(ret_addr)
  );

  pc_ret_stack #(.DEPTH(STACK_DEPTH)) u_stack (
    .clk(clk), .rst_n(rst_n), .push(push_w), .pop(pop_w),
    .push_val(ret_addr), .top(stk_top), .depth(stk_depth)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= RESET_ADDR;
    else        pc_q <= pc_d;
  end

  assign fetch_addr = pc_q;
  assign pc_low     = pc_q[LOW_W-1:0];
endmodule

// File: rtl/pc_seq_chk.sv
module pc_seq_chk
  import pc_pkg::*;
#(
  parameter int CNT_W = 2,
  parameter int DEPTH = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [3:0]        op,
  input logic [ADDR_W-1:0] imm_addr,
  input logic [LOW_W-1:0]  alu_res,
  input logic [PAGE_W-1:0] page_sel,
  input logic [ADDR_W-1:0] fetch_addr,
  input logic              push,
  input logic [CNT_W-1:0]  depth
);
  a_r2_seq_step: assert property (@(posedge clk) disable iff (!rst_n)
    op == 4'd0 |=> fetch_addr == $past(fetch_addr) + ADDR_W'(1));

  a_r3_skip_step: assert property (@(posedge clk) disable iff (!rst_n)
    op == 4'd1 |=> fetch_addr == $past(fetch_addr) + ADDR_W'(2));

  a_r4_regwr_page: assert property (@(posedge clk) disable iff (!rst_n)
    op == 4'd2 |=> fetch_addr == {$past(page_sel), 1'b0, $past(alu_res)});

  a_r7_long_jump: assert property (@(posedge clk) disable iff (!rst_n)
    op == 4'd5 |=> fetch_addr == $past(imm_addr));

  a_r6_push_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (push && depth < CNT_W'(DEPTH)) |=> depth == $past(depth) + CNT_W'(1));

  a_r9_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
    depth <= CNT_W'(DEPTH));
endmodule

bind pc_seq pc_seq_chk #(.CNT_W($clog2(STACK_DEPTH+1)), .DEPTH(STACK_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .op(op), .imm_addr(imm_addr), .alu_res(alu_res),
  .page_sel(page_sel), .fetch_addr(fetch_addr), .push(push_w), .depth(stk_depth)
);

// File: tb/tb_pc_seq.sv
module tb_pc_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  op = 4'd0;
  logic [10:0] imm_addr = '0;
  logic [7:0]  alu_res = '0;
  logic [1:0]  page_sel = '0;
  logic [10:0] fetch_addr;
  logic [7:0]  pc_low;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pc_seq dut (
    .clk(clk), .rst_n(rst_n), .op(op), .imm_addr(imm_addr), .alu_res(alu_res),
    .page_sel(page_sel), .fetch_addr(fetch_addr), .pc_low(pc_low)
  );

  // {op, imm, alu, page, expected address}
  localparam int NV = 14;
  localparam logic [35:0] VEC [NV] = '{
    {4'd0, 11'h000, 8'h00, 2'd0, 11'h000},
    {4'd0, 11'h000, 8'h00, 2'd3, 11'h001},
    {4'd1, 11'h000, 8'h00, 2'd0, 11'h003},
    {4'd3, 11'h1A5, 8'h00, 2'd2, 11'h5A5},
    {4'd4, 11'h740, 8'h00, 2'd1, 11'h240},
    {4'd2, 11'h000, 8'h77, 2'd3, 11'h677},
    {4'd4, 11'h110, 8'h00, 2'd0, 11'h010},
    {4'd6, 11'h7F0, 8'h00, 2'd3, 11'h7F0},
    {4'd7, 11'h000, 8'h00, 2'd0, 11'h011},
    {4'd8, 11'h055, 8'h00, 2'd0, 11'h678},
    {4'd7, 11'h000, 8'h00, 2'd0, 11'h678},
    {4'd5, 11'h123, 8'h00, 2'd2, 11'h123},
    {4'd1, 11'h000, 8'h00, 2'd0, 11'h125},
    {4'd0, 11'h000, 8'h00, 2'd1, 11'h126}
  };

  function automatic string tag_of(input logic [3:0] o);
    case (o)
      4'd0: return "R2";
      4'd1: return "R3";
      4'd2: return "R4";
      4'd3: return "R5";
      4'd4: return "R6";
      4'd5, 4'd6: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input string req, input logic [10:0] exp);
    checks++;
    if (fetch_addr !== exp || pc_low !== exp[7:0]) begin
      failures++;
      $display("FAIL %s: fetch_addr=%h pc_low=%h expected %h/%h",
               req, fetch_addr, pc_low, exp, exp[7:0]);
    end
  endtask

  // Drive at a falling edge, let one rising edge pass, return at the next falling edge.
  task automatic step(input logic [3:0] o, input logic [10:0] im,
                      input logic [7:0] a, input logic [1:0] pg);
    op = o; imm_addr = im; alu_res = a; page_sel = pg;
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    check("R1 reset address", 11'h7FF);
    check("R11 low byte in reset", 11'h7FF);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][35:32], VEC[i][31:21], VEC[i][20:13], VEC[i][12:11]);
      check(tag_of(VEC[i][35:32]), VEC[i][10:0]);
    end
    // Vector 10 returned 678h after the stack was emptied: R10 repeat of last entry.

    // Wrap-around at the top of memory.
    step(4'd5, 11'h7FF, 8'h00, 2'd0);
    step(4'd0, 11'h000, 8'h00, 2'd0);
    check("R2 wrap 7FF->000", 11'h000);
    step(4'd5, 11'h7FE, 8'h00, 2'd0);
    step(4'd1, 11'h000, 8'h00, 2'd0);
    check("R3 skip wrap 7FE->000", 11'h000);
    step(4'd5, 11'h7FF, 8'h00, 2'd0);
    step(4'd1, 11'h000, 8'h00, 2'd0);
    check("R3 skip wrap 7FF->001", 11'h001);

    // Unused op codes act as sequential.
    step(4'd12, 11'h3FF, 8'hAA, 2'd3);
    check("R11 unused code is sequential", 11'h002);

    // Three calls deep, then unwind past empty.
    step(4'd5, 11'h100, 8'h00, 2'd0);
    step(4'd4, 11'h020, 8'h00, 2'd0);
    step(4'd4, 11'h030, 8'h00, 2'd0);
    step(4'd4, 11'h040, 8'h00, 2'd0);
    check("R6 third short call target", 11'h040);
    step(4'd7, 11'h000, 8'h00, 2'd0);
    check("R8 return newest", 11'h031);
    step(4'd8, 11'h0EE, 8'h00, 2'd0);
    check("R9 oldest entry dropped", 11'h021);
    step(4'd7, 11'h000, 8'h00, 2'd0);
    check("R10 empty pop repeats last", 11'h021);

    // Reset in mid-run clears the stack.
    rst_n = 1'b0;
    op = 4'd0;
    @(negedge clk);
    check("R1 mid-run reset address", 11'h7FF);
    rst_n = 1'b1;
    step(4'd7, 11'h000, 8'h00, 2'd0);
    check("R10 empty pop after reset", 11'h000);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule